// File: doc/BRIEF.md
# Free-Running 64-bit Timer with Self-Reloading Comparator

This block is a free-running 64-bit up-counter behind a small word-wide register interface. Software reads the count as two 32-bit halves and loads a 64-bit compare value as two 32-bit words. When the count reaches the compare value, a sticky status flag is set. If interrupts are enabled, a one-cycle interrupt pulse is also driven.

A programmable 32-bit step can be added to the compare value on every match. Each new deadline is then measured from the previous deadline and not from the time software serviced the interrupt, so periodic interrupts do not drift. The compare value is locked while comparison is enabled. To move a deadline, software turns comparison off, writes both halves and turns it back on.

The register port is a simple single-cycle access. A write is taken on the clock edge on which `wr_en` is high. `rd_data` is a combinational function of `addr`.

Top module: `gtmr_top`

## Requirements
- R1: After reset the count, control, status, compare and step registers all read zero and `irq` is low.
- R2: The count (byte address 0x00 for bits 31:0, 0x04 for bits 63:32) rises by exactly one per clock while control bit 0 (run) is 1. It holds while that bit is 0. Writes to 0x00 and 0x04 have no effect.
- R3: Control at 0x08 keeps bits 3:0 (bit 0 run, bit 1 compare enable, bit 2 interrupt enable, bit 3 auto-step) and reads the other bits as zero. Compare low/high at 0x10/0x14 and step at 0x18 read back what was written.
- R4: A match exists while run and compare enable are both 1 and the 64-bit count is greater than or equal to the compare value. The status flag (0x0C bit 0) reads 1 from the cycle after the first matching cycle.
- R5: The status flag is sticky. Writing 1 to 0x0C bit 0 clears it, and writing 0 leaves it set. If a match exists in the same cycle as the clear, the flag stays set.
- R6: Writes to compare low/high are ignored while compare enable is 1. They take effect while it is 0.
- R7: On a match with auto-step (control bit 3) set, the compare value becomes the old compare value plus the step register.
- R8: `irq` is a single-cycle pulse, raised in the cycle the status flag goes from 0 to 1, only if interrupt enable is 1. It stays low while interrupt enable is 0.
- R9: All 64 bits take part in the comparison. A nonzero compare high word keeps a low count from matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 5 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situation to reach is a periodic reload that must land on exact deadlines. The bench enables auto-step with a short step and clears the flag after each pulse. It reads the count in the pulse cycle and checks that successive pulses arrive exactly one step apart. The clear-versus-match race is another hard case. The bench reaches it by leaving comparison enabled with the count already past the deadline, so every clear write collides with a live match. The 64-bit compare cannot be driven to a carry in a short run, so the high-word case is covered by loading a nonzero high compare word and confirming that no match appears.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 5'h00;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 5'h04;
  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] A_STAT   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 5'h10;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 5'h14;
  localparam logic [ADDR_W-1:0] A_STEP   = 5'h18;

  typedef struct packed {
    logic astep;
    logic ien;
    logic cen;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/gtmr_rst_sync.sv
module gtmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/gtmr_compare.sv
module gtmr_compare #(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 2*DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [DW-1:0]    wdata,
  input  logic             run,
  input  logic             cen,
  input  logic             astep,
  input  logic [DW-1:0]    step,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             match
);
  localparam int unsigned HI_W = CNT_W - DW;

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             hit;

  assign hit = run && cen && (cnt >= cmp_q);

  always_comb begin
    cmp_d = cmp_q;
    if (!cen) begin
      if (wr_lo) cmp_d[DW-1:0]     = wdata;
      if (wr_hi) cmp_d[CNT_W-1:DW] = wdata[HI_W-1:0];
    end else if (hit && astep) begin
      cmp_d = cmp_q + {{HI_W{1'b0}}, step};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_d;
  end

  assign cmp   = cmp_q;
  assign match = hit;
endmodule

// File: rtl/gtmr_regs.sv
module gtmr_regs
  import gtmr_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 2*DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              match,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp,
  output ctrl_t             ctrl,
  output logic [DW-1:0]     step,
  output logic              status,
  output logic              wr_cmp_lo,
  output logic              wr_cmp_hi,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);
  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] step_q, step_d;
  logic          stat_q, stat_d;
  logic          irq_q, irq_d;
  logic          clr;

  assign wr_cmp_lo = wr_en && (addr == A_CMP_LO);
  assign wr_cmp_hi = wr_en && (addr == A_CMP_HI);
  assign clr       = wr_en && (addr == A_STAT) && wr_data[0];

  always_comb begin
    ctrl_d = ctrl_q;
    step_d = step_q;
    if (wr_en && addr == A_CTRL) ctrl_d = ctrl_t'(wr_data[3:0]);
    if (wr_en && addr == A_STEP) step_d = wr_data;
    stat_d = match || (stat_q && !clr);
    irq_d  = ctrl_q.ien && match && !stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      step_q <= '0;
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      step_q <= step_d;
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_CNT_LO: rd_data = cnt[DW-1:0];
      A_CNT_HI: rd_data = DW'(cnt[CNT_W-1:DW]);
      A_CTRL:   rd_data = DW'(ctrl_q);
      A_STAT:   rd_data = DW'(stat_q);
      A_CMP_LO: rd_data = cmp[DW-1:0];
      A_CMP_HI: rd_data = DW'(cmp[CNT_W-1:DW]);
      A_STEP:   rd_data = step_q;
      default:  rd_data = '0;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign step   = step_q;
  assign status = stat_q;
  assign irq    = irq_q;
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
  import gtmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);
  localparam int unsigned CNT_W = 2*DW;

  logic             rst_n_s;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic             match;
  ctrl_t            ctrl;
  logic [DW-1:0]    step;
  logic             status;
  logic             wr_cmp_lo, wr_cmp_hi;

  gtmr_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  gtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .en(ctrl.run), .cnt(cnt)
  );

  gtmr_compare #(.DW(DW), .CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n_s), .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi),
    .wdata(wr_data), .run(ctrl.run), .cen(ctrl.cen), .astep(ctrl.astep),
    .step(step), .cnt(cnt), .cmp(cmp), .match(match)
  );

  gtmr_regs #(.DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .match(match), .cnt(cnt), .cmp(cmp),
    .ctrl(ctrl), .step(step), .status(status), .wr_cmp_lo(wr_cmp_lo),
    .wr_cmp_hi(wr_cmp_hi), .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker #(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 2*DW
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             wr_en,
  input logic [4:0]       addr,
  input logic [DW-1:0]    wr_data,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic [DW-1:0]    step,
  input logic [3:0]       ctrl,
  input logic             status,
  input logic             irq
);
  logic clr_wr;
  assign clr_wr = wr_en && (addr == 5'h0C) && wr_data[0];

  logic hit;
  assign hit = ctrl[0] && ctrl[1] && (cnt >= cmp);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl[0] |=> cnt == $past(cnt) + 1);  // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctrl[0] |=> $stable(cnt));  // R2
  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n_s)
    hit |=> status);  // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    status && !clr_wr |=> status);  // R5
  AST_CMP_LOCK: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl[1] && !(hit && ctrl[3]) |=> $stable(cmp));  // R6
  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    hit && ctrl[3] |=> cmp == $past(cmp) + CNT_W'($past(step)));  // R7
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |=> !irq);  // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> status && $rose(status));  // R8
endmodule

bind gtmr_top gtmr_checker #(.DW(DW), .CNT_W(2*DW)) chk_i (
  .clk(clk), .rst_n_s(rst_n_s), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .cnt(cnt), .cmp(cmp), .step(step),
  .ctrl(ctrl), .status(status), .irq(irq)
);

// File: tb/gtmr_top_tb_top.sv
module gtmr_top_tb_top;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq;

  int checks;
  int errors;

  gtmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(5'h00, v); check("R1 cnt_lo", v, 0);
    rd(5'h04, v); check("R1 cnt_hi", v, 0);
    rd(5'h08, v); check("R1 ctrl", v, 0);
    rd(5'h0C, v); check("R1 status", v, 0);
    rd(5'h10, v); check("R1 cmp_lo", v, 0);
    rd(5'h14, v); check("R1 cmp_hi", v, 0);
    rd(5'h18, v); check("R1 step", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_count();
    logic [31:0] a, b;
    do_reset();
    wr(5'h08, 32'h1);
    @(negedge clk); addr = 5'h00; #1; a = rd_data;
    repeat (10) @(negedge clk);
    #1; b = rd_data;
    check("R2 run step", b - a, 10);
    wr(5'h08, 32'h0);
    @(negedge clk); addr = 5'h00; #1; a = rd_data;
    repeat (10) @(negedge clk);
    #1; b = rd_data;
    check("R2 hold", b - a, 0);
    wr(5'h00, 32'h1234_5678);
    wr(5'h04, 32'h0000_0055);
    rd(5'h00, b); check("R2 cnt_lo read-only", b, a);
    rd(5'h04, b); check("R2 cnt_hi read-only", b, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    do_reset();
    wr(5'h08, 32'hFFFF_FFFA);
    rd(5'h08, v); check("R3 ctrl width", v, 32'hA);
    wr(5'h08, 32'h0);
    wr(5'h18, 32'hCAFE_0123);
    rd(5'h18, v); check("R3 step", v, 32'hCAFE_0123);
    wr(5'h10, 32'h1111_2222);
    wr(5'h14, 32'h3333_4444);
    rd(5'h10, v); check("R3 cmp_lo", v, 32'h1111_2222);
    rd(5'h14, v); check("R3 cmp_hi", v, 32'h3333_4444);
  endtask

  task automatic t_match();
    logic [31:0] v;
    int seen;
    int guard;
    do_reset();
    wr(5'h10, 32'd20);
    wr(5'h08, 32'h7);
    seen = 0; guard = 0;
    while (!seen && guard < 100) begin
      @(negedge clk); addr = 5'h00; #1;
      if (irq) begin
        seen = 1;
        check("R4 match at count>=cmp", rd_data, 21);
      end
      guard++;
    end
    check("R8 pulse seen", seen, 1);
    @(negedge clk); #1;
    check("R8 single cycle", {31'b0, irq}, 0);
    rd(5'h0C, v); check("R4 status set", v, 1);
    wr(5'h10, 32'd99);
    rd(5'h10, v); check("R6 cmp locked", v, 20);
    wr(5'h0C, 32'h1);
    rd(5'h0C, v); check("R5 match beats clear", v, 1);
    wr(5'h08, 32'h5);
    wr(5'h0C, 32'h0);
    rd(5'h0C, v); check("R5 write0 no effect", v, 1);
    wr(5'h0C, 32'h1);
    rd(5'h0C, v); check("R5 write1 clears", v, 0);
    wr(5'h10, 32'd99);
    rd(5'h10, v); check("R6 cmp unlocked", v, 99);
  endtask

  task automatic t_autostep();
    logic [31:0] prev;
    int n;
    int guard;
    do_reset();
    wr(5'h10, 32'd20);
    wr(5'h18, 32'd15);
    wr(5'h08, 32'hF);
    n = 0; guard = 0; prev = 0;
    while (n < 3 && guard < 300) begin
      @(negedge clk); addr = 5'h00; #1;
      if (irq) begin
        if (n == 0) check("R7 first deadline", rd_data, 21);
        else        check("R7 period", rd_data - prev, 15);
        prev = rd_data;
        n++;
        wr(5'h0C, 32'h1);
      end
      guard++;
    end
    check("R7 pulses", n, 3);
  endtask

  task automatic t_noirq();
    logic [31:0] v;
    int pulses;
    do_reset();
    wr(5'h10, 32'd5);
    wr(5'h08, 32'h3);
    pulses = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      if (irq) pulses++;
    end
    check("R8 no irq when disabled", pulses, 0);
    rd(5'h0C, v); check("R8 status still set", v, 1);
  endtask

  task automatic t_high();
    logic [31:0] v;
    int pulses;
    do_reset();
    wr(5'h14, 32'd1);
    wr(5'h08, 32'h7);
    pulses = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #1;
      if (irq) pulses++;
    end
    check("R9 no early irq", pulses, 0);
    rd(5'h0C, v); check("R9 no match", v, 0);
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    t_reset();
    t_count();
    t_regs();
    t_match();
    t_autostep();
    t_noirq();
    t_high();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule